// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block turns a fast module clock into the serial clock of a serial-peripheral transfer engine. Two divide rules are available, and one select bit picks between them. The linear rule divides by 2·(N+1) using an 8-bit field. The exponential rule divides by 2^(N+1) using a 4-bit field. Either way, the output has a 50% duty cycle, so one half-period is N+1 module clocks in linear mode and 2^N module clocks in exponential mode.

Next to the serial clock, the block produces two single-cycle strobes. One marks each edge that leaves the idle level (leading) and the other marks each edge that returns to it (trailing). The transfer engine maps these strobes to shift or sample according to its clock phase. Pulses are produced only while the transfer-active input is high. Between transfers the serial clock rests at the idle polarity and the half-period counter rests at zero.

The divider settings and the polarity are captured on every idle cycle and then frozen for the length of a transfer. A change written during a transfer therefore applies from the next transfer on.

Top module: `sclk_divgen`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: While `xfer_active` is low, `sclk` equals the `idle_pol` value of the previous cycle and neither strobe pulses.
- R3: With `lin_mode` = 1, every half-period of `sclk` lasts `lin_div`+1 module clocks.
- R4: With `lin_mode` = 0, every half-period of `sclk` lasts 2^`exp_div` module clocks, including `exp_div` = 15 (32768 clocks).
- R5: The first `sclk` edge of a transfer appears after exactly one half-period of cycles in which `xfer_active` is sampled high.
- R6: Each `sclk` edge comes with exactly one strobe, in the same cycle. `lead_stb` marks the 1st, 3rd, … edges, which move away from the idle level. `trail_stb` marks the 2nd, 4th, … edges. Neither strobe pulses in a cycle without an edge.
- R7: Changes to `lin_mode`, `lin_div`, `exp_div` or `idle_pol` while `xfer_active` is high do not alter the running transfer. They apply to the next transfer.
- R8: With `idle_pol` = 1 the clock idles high, and the first (leading) edge of a transfer is a falling one.
- R9: Dropping `xfer_active` in the middle of a half-period returns `sclk` to the idle level on the next cycle. The next transfer again waits a full half-period before its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | High while a transfer is running |
| idle_pol | input | 1 | Idle level of the serial clock |
| lin_mode | input | 1 | 1 selects the linear divider, 0 the exponential one |
| lin_div | input | 8 | Linear divide field N (divide by 2·(N+1)) |
| exp_div | input | 4 | Exponential divide field N (divide by 2^(N+1)) |
| sclk | output | 1 | Serial clock, 50% duty |
| lead_stb | output | 1 | One-cycle pulse with each edge leaving the idle level |
| trail_stb | output | 1 | One-cycle pulse with each edge returning to the idle level |

## Verification
The divider is exercised at the extremes of both fields: linear N of 0, 3 and 255, and exponential N of 0, 3, 10 and 15. Pairs such as linear N=0 against exponential N=0 must give the same period, while linear N=3 against exponential N=3 must not; this tells apart a swapped mode bit and an off-by-one in either rule. Both idle polarities are run, which separates leading from trailing edges and rising from falling ones. Directed cases change the settings in the middle of a transfer and abort a transfer halfway through a half-period. These show whether the configuration is frozen and whether the counter is cleared between transfers.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int unsigned LIN_W_DEF = 8;
  localparam int unsigned EXP_W_DEF = 4;

  // Counter width that holds the largest terminal count of either mode.
  function automatic int unsigned term_width(input int unsigned lin_w, input int unsigned exp_w);
    int unsigned exp_bits;
    exp_bits = (32'd1 << exp_w) - 32'd1;
    return (lin_w > exp_bits) ? lin_w : exp_bits;
  endfunction
endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             lin_mode,
  input  logic             pol_in,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [EXP_W-1:0] exp_div,
  output logic [CNT_W-1:0] term_q,
  output logic             pol_q
);
  localparam int unsigned SH_W = CNT_W + 1;

  logic [SH_W-1:0]  pow_val;
  logic [CNT_W-1:0] term_d;

  // Terminal count = half-period minus one.
  always_comb begin
    pow_val = SH_W'(1) << exp_div;
    if (lin_mode) term_d = CNT_W'(lin_div);
    else          term_d = CNT_W'(pow_val - SH_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      pol_q  <= 1'b0;
    end else if (load) begin
      term_q <= term_d;
      pol_q  <= pol_in;
    end
  end
endmodule

// File: rtl/sclk_half_cnt.sv
module sclk_half_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] term,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick = run && (cnt_q == term);

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic idle_lvl,
  input  logic pol_q,
  output logic sclk_q,
  output logic lead_q,
  output logic trail_q
);
  logic sclk_d, lead_d, trail_d;

  always_comb begin
    sclk_d  = sclk_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!run) begin
      sclk_d = idle_lvl;
    end else if (tick) begin
      sclk_d  = ~sclk_q;
      lead_d  = (sclk_q == pol_q);
      trail_d = (sclk_q != pol_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end
endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W = LIN_W_DEF,
  parameter int unsigned EXP_W = EXP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic             idle_pol,
  input  logic             lin_mode,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [EXP_W-1:0] exp_div,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int unsigned CNT_W = term_width(LIN_W, EXP_W);

  logic             rst_core_n;
  logic [CNT_W-1:0] term_q;
  logic             pol_q;
  logic             tick;

  sclk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_core_n)
  );

  sclk_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (!xfer_active),
    .lin_mode (lin_mode),
    .pol_in   (idle_pol),
    .lin_div  (lin_div),
    .exp_div  (exp_div),
    .term_q   (term_q),
    .pol_q    (pol_q)
  );

  sclk_half_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (xfer_active),
    .term  (term_q),
    .tick  (tick)
  );

  sclk_edge_gen u_edge (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (xfer_active),
    .tick     (tick),
    .idle_lvl (idle_pol),
    .pol_q    (pol_q),
    .sclk_q   (sclk),
    .lead_q   (lead_stb),
    .trail_q  (trail_stb)
  );
endmodule

// File: rtl/sclk_divgen_chk.sv
module sclk_divgen_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_active,
  input logic idle_pol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  logic [1:0] up_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             up_q <= 2'd0;
    else if (up_q != 2'd3)  up_q <= up_q + 2'd1;
  end
  assign armed = (up_q == 2'd3);

  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (!sclk && !lead_stb && !trail_stb);
  end

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(xfer_active) |-> sclk == $past(idle_pol));

  p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(xfer_active) |-> !lead_stb && !trail_stb);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lead_stb, trail_stb}) <= 1);

  p_strobe_has_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (lead_stb || trail_stb) |-> sclk != $past(sclk));

  p_edge_has_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(xfer_active) && (sclk != $past(sclk)) |-> lead_stb || trail_stb);
endmodule

bind sclk_divgen sclk_divgen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_active (xfer_active),
  .idle_pol    (idle_pol),
  .sclk        (sclk),
  .lead_stb    (lead_stb),
  .trail_stb   (trail_stb)
);

// File: tb/sclk_divgen_tb.sv
module sclk_divgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {lin_mode, idle_pol, lin_div[7:0], exp_div[3:0], half[17:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd0,   4'd0,  18'd1},
    {1'b0, 1'b0, 8'd0,   4'd0,  18'd1},
    {1'b1, 1'b0, 8'd3,   4'd0,  18'd4},
    {1'b0, 1'b1, 8'd0,   4'd3,  18'd8},
    {1'b1, 1'b1, 8'd255, 4'd0,  18'd256},
    {1'b0, 1'b0, 8'd9,   4'd10, 18'd1024},
    {1'b0, 1'b1, 8'd0,   4'd15, 18'd32768}
  };

  logic       clk, rst_n, xfer_active, idle_pol, lin_mode;
  logic [7:0] lin_div;
  logic [3:0] exp_div;
  logic       sclk, lead_stb, trail_stb;
  int         n_tests, n_fail;

  sclk_divgen u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .idle_pol(idle_pol),
    .lin_mode(lin_mode), .lin_div(lin_div), .exp_div(exp_div),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the next sclk change; reports gap, strobes and stray strobes.
  task automatic next_edge(input int limit, output int gap, output logic ld,
                           output logic tr, output logic lvl, output int stray);
    logic prev;
    prev = sclk; gap = 0; ld = 1'b0; tr = 1'b0; lvl = sclk; stray = 0;
    while (gap < limit) begin
      @(negedge clk);
      gap++;
      if (sclk !== prev) begin
        ld = lead_stb; tr = trail_stb; lvl = sclk;
        break;
      end else if (lead_stb || trail_stb) begin
        stray++;
      end
    end
  endtask

  task automatic setup(input logic lm, input logic pol, input logic [7:0] ld, input logic [3:0] ed);
    @(negedge clk);
    xfer_active = 1'b0; lin_mode = lm; idle_pol = pol; lin_div = ld; exp_div = ed;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_xfer(input int half, input int edges, input logic pol, input string req);
    int gap, stray;
    logic ld, tr, lvl;
    check(sclk == pol, "R2 idle level", int'(sclk), int'(pol));
    xfer_active = 1'b1;
    for (int e = 0; e < edges; e++) begin
      next_edge(half + 4, gap, ld, tr, lvl, stray);
      check(gap == half, (e == 0) ? "R5 first edge delay" : req, gap, half);
      check(ld == (e % 2 == 0) && tr == (e % 2 == 1), "R6 strobe kind",
            int'({ld, tr}), (e % 2 == 0) ? 2 : 1);
      check(lvl == ((e % 2 == 0) ? ~pol : pol), "R8 edge direction", int'(lvl),
            int'((e % 2 == 0) ? ~pol : pol));
      check(stray == 0, "R6 stray strobe", stray, 0);
    end
    xfer_active = 1'b0;
    @(negedge clk);
    check(sclk == pol && !lead_stb && !trail_stb, "R2 return to idle",
          int'({sclk, lead_stb, trail_stb}), int'({pol, 2'b00}));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int gap, stray;
    logic ld, tr, lvl;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; xfer_active = 1'b0; idle_pol = 1'b1; lin_mode = 1'b1;
    lin_div = 8'd0; exp_div = 4'd0;
    repeat (3) @(negedge clk);
    // R1: reset state, even with idle_pol high
    check(!sclk && !lead_stb && !trail_stb, "R1 reset outputs",
          int'({sclk, lead_stb, trail_stb}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sclk == 1'b1, "R2 idle after reset", int'(sclk), 1);

    // Table walk: R3 linear, R4 exponential, R8 inverted polarity
    for (int i = 0; i < NVEC; i++) begin
      setup(VEC[i][31], VEC[i][30], VEC[i][29:22], VEC[i][21:18]);
      run_xfer(int'(VEC[i][17:0]), (VEC[i][17:0] > 18'd2000) ? 2 : 4, VEC[i][30],
               VEC[i][31] ? "R3 linear half-period" : "R4 exponential half-period");
    end

    // R7: settings changed mid-transfer are ignored until the next one
    setup(1'b1, 1'b0, 8'd2, 4'd0);
    xfer_active = 1'b1;
    next_edge(10, gap, ld, tr, lvl, stray);
    check(gap == 3, "R7 first gap", gap, 3);
    lin_mode = 1'b0; exp_div = 4'd1; idle_pol = 1'b1;
    for (int e = 0; e < 3; e++) begin
      next_edge(10, gap, ld, tr, lvl, stray);
      check(gap == 3, "R7 frozen period", gap, 3);
      check(tr == (e % 2 == 0), "R7 frozen polarity", int'(tr), int'(e % 2 == 0));
    end
    xfer_active = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R7 new idle level", int'(sclk), 1);
    @(negedge clk);
    run_xfer(2, 2, 1'b1, "R7 new period applied");

    // R9: abort inside a half-period, then restart from a cleared counter
    setup(1'b1, 1'b0, 8'd4, 4'd0);
    xfer_active = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R9 no edge before abort", int'(sclk), 0);
    xfer_active = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !lead_stb, "R9 idle after abort", int'(sclk), 0);
    run_xfer(5, 2, 1'b0, "R9 full half-period after restart");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule